// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timer

This block runs single accesses on an 8080-style parallel display bus. A host asks for one access with a one-clock request. The request says whether the access is a command or a data transfer and whether it reads or writes. The block then counts timing ticks and places the chip-select, write-strobe and read-strobe edges at tick positions taken from two packed timing words. It drives the command/data select line and the output enable of the data pins. On a read it captures the data pins at a programmed access tick. A one-clock done pulse marks the end of the strobe cycle. After that, an optional recovery gap keeps the bus quiet before the next access may start.

A granularity input doubles the length of each tick. Every output pin has its own polarity bit. Timing values that break the ordering rules are raised to the smallest legal value, so the bus never sees a zero-width or inverted strobe. The timing words and the granularity bit are sampled when a request is accepted. The polarity bits act live.

Top module: `pbus_strobe_timer`

## Requirements
- R1: Timing word A holds the fields at these bit positions: chip-select assert tick [3:0], chip-select release tick [9:4], write-strobe assert [13:10], write-strobe release [19:14], read-strobe assert [23:20], read-strobe release [29:24]. Assert ticks are 4 bits wide and release ticks are 6 bits wide.
- R2: Timing word B holds the fields at these bit positions: write cycle length [5:0], read cycle length [11:6], recovery gap [17:12], read access tick [27:22].
- R3: An accepted request starts the tick counter at 0. Each strobe is active while the counter is at least its assert tick and below its release tick. When the counter has reached the cycle length and that tick ends, `done` is high for exactly one clock. The strobe cycle therefore lasts length+1 ticks.
- R4: With `slow_tick`=0 a tick is one clock. With `slow_tick`=1 a tick is two clocks.
- R5: Release ticks are clamped upward. Write release is at least write assert+1. Read release is at least read assert+1. Chip-select release is at least chip-select assert+1 and at least both clamped strobe releases.
- R6: The access tick is at least read assert+1. The write cycle length is at least the clamped write release. The read cycle length is at least the clamped read release and at least the clamped access tick.
- R7: `pol` bit 0 controls CS, bit 1 WE, bit 2 RE and bit 3 A0. A strobe pin equals its polarity bit while active and the inverse while inactive, so 0 gives an active-low strobe. The A0 pin is the logical select (1 for data, 0 for command) XOR bit 3.
- R8: On a write only WE pulses and RE stays inactive. `bus_oe` is high exactly while CS is active, and `bus_dout` carries the write data latched at acceptance.
- R9: On a read only RE pulses, WE stays inactive and `bus_oe` stays low. `bus_din` is captured at the clock edge that ends the access tick. `rd_data` then holds that value until the next read, and writes do not change it.
- R10: A0 stays constant through the whole access. `req_cmd`=1 selects command (logical 0).
- R11: After `done`, `busy` stays high for gap ticks with every strobe inactive. A request seen while `busy` is high is ignored.
- R12: Changes to the timing words, `slow_tick` or `wr_data` after acceptance do not affect the access in progress.
- R13: After reset `busy`, `done`, `bus_oe` and `rd_data` are zero and all strobes are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken while idle |
| req_cmd | input | 1 | 1 = command access, 0 = data access |
| req_rd | input | 1 | 1 = read access, 0 = write access |
| wr_data | input | DATA_W | Write data |
| time_a | input | 32 | Strobe edge word |
| time_b | input | 32 | Cycle length, gap and access tick word |
| slow_tick | input | 1 | Two clocks per tick when set |
| pol | input | 4 | Pin polarity bits (CS, WE, RE, A0) |
| bus_din | input | DATA_W | Data pins as read from the bus |
| cs_o | output | 1 | Chip-select pin |
| we_o | output | 1 | Write-strobe pin |
| re_o | output | 1 | Read-strobe pin |
| a0_o | output | 1 | Command/data select pin |
| bus_oe | output | 1 | Data pin output enable |
| bus_dout | output | DATA_W | Data driven onto the pins |
| rd_data | output | DATA_W | Last captured read data |
| busy | output | 1 | Access or recovery gap in progress |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The bench steps the data pins to a new value every clock during a read. A capture that comes one clock early or late, or that ignores the doubled tick, therefore gives a wrong `rd_data` value. Inverted and collapsed timing fields are driven on purpose. A design that skips a clamp would show a strobe that never asserts, or a cycle that ends before its release or access tick. Timing words, granularity and write data are scrambled, and a second request is raised, in the middle of an access. A design that samples live configuration, or restarts while busy, would move edges or shorten the recovery gap. A read followed by a write shows whether `rd_data` stays held.

// File: rtl/pbus_pkg.sv
`timescale 1ns/1ps
package pbus_pkg;
  localparam int WORD_W = 32;
  localparam int ON_W   = 4;
  localparam int OFF_W  = 6;
  localparam int NPOL   = 4;
  localparam int NSTB   = 3;   // strobe index: 0 chip select, 1 write, 2 read

  typedef logic [OFF_W-1:0] tick_t;

  typedef struct packed {
    tick_t cs_on;
    tick_t cs_off;
    tick_t we_on;
    tick_t we_off;
    tick_t re_on;
    tick_t re_off;
    tick_t wr_len;
    tick_t rd_len;
    tick_t gap;
    tick_t acc;
  } tcfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} st_t;

  function automatic tick_t tmax(input tick_t a, input tick_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pbus_time_clamp.sv
`timescale 1ns/1ps
module pbus_time_clamp
  import pbus_pkg::*;
(
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output tcfg_t             cfg
);
  tick_t cs_on, cs_off, we_on, we_off, re_on, re_off;
  tick_t wr_len, rd_len, gap, acc;
  tick_t we_off_c, re_off_c, cs_off_c, acc_c;
  logic  unused_bits;

  // field extraction; positions are fixed by the word format
  assign cs_on  = tick_t'(word_a[3:0]);
  assign cs_off = word_a[9:4];
  assign we_on  = tick_t'(word_a[13:10]);
  assign we_off = word_a[19:14];
  assign re_on  = tick_t'(word_a[23:20]);
  assign re_off = word_a[29:24];
  assign wr_len = word_b[5:0];
  assign rd_len = word_b[11:6];
  assign gap    = word_b[17:12];
  assign acc    = word_b[27:22];
  assign unused_bits = ^{word_a[31:30], word_b[21:18], word_b[31:28]};

  // ordering repair: each value raised to its smallest legal value
  always_comb begin
    we_off_c = tmax(we_off, we_on + 1'b1);
    re_off_c = tmax(re_off, re_on + 1'b1);
    cs_off_c = tmax(tmax(cs_off, cs_on + 1'b1), tmax(we_off_c, re_off_c));
    acc_c    = tmax(acc, re_on + 1'b1);
    cfg.cs_on  = cs_on;
    cfg.cs_off = cs_off_c;
    cfg.we_on  = we_on;
    cfg.we_off = we_off_c;
    cfg.re_on  = re_on;
    cfg.re_off = re_off_c;
    cfg.wr_len = tmax(wr_len, we_off_c);
    cfg.rd_len = tmax(tmax(rd_len, re_off_c), acc_c);
    cfg.gap    = gap;
    cfg.acc    = acc_c;
  end
endmodule

// File: rtl/pbus_tick_gen.sv
`timescale 1ns/1ps
module pbus_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic slow,
  output logic tick
);
  logic ph_q, ph_d, ph_en;

  always_comb begin
    ph_en = start | (run & slow);
    ph_d  = start ? 1'b0 : ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
    end else if (ph_en) begin
      ph_q <= ph_d;
    end
  end

  assign tick = run & (~slow | ph_q);
endmodule

// File: rtl/pbus_win.sv
`timescale 1ns/1ps
module pbus_win
  import pbus_pkg::*;
#(
  parameter int N = NSTB
) (
  input  tick_t                     t,
  input  logic [N-1:0][OFF_W-1:0]   on_t,
  input  logic [N-1:0][OFF_W-1:0]   off_t,
  output logic [N-1:0]              hit
);
  for (genvar i = 0; i < N; i++) begin : g_win
    assign hit[i] = (t >= on_t[i]) && (t < off_t[i]);
  end
endmodule

// File: rtl/pbus_strobe_timer.sv
`timescale 1ns/1ps
module pbus_strobe_timer
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_cmd,
  input  logic              req_rd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WORD_W-1:0] time_a,
  input  logic [WORD_W-1:0] time_b,
  input  logic              slow_tick,
  input  logic [NPOL-1:0]   pol,
  input  logic [DATA_W-1:0] bus_din,
  output logic              cs_o,
  output logic              we_o,
  output logic              re_o,
  output logic              a0_o,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // state
  st_t               st_q, st_d;
  tick_t             t_q, t_d;
  tcfg_t             cfg_q, cfg_in;
  logic              slow_q, rd_q, a0_q, done_q, done_d;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic              start, run, act, tick, cap_en;
  tick_t             cur_len;
  logic [NSTB-1:0]   hit;
  logic              cs_act, we_act, re_act;

  pbus_time_clamp u_clamp (
    .word_a (time_a),
    .word_b (time_b),
    .cfg    (cfg_in)
  );

  assign start = (st_q == ST_IDLE) & req;
  assign run   = (st_q != ST_IDLE);
  assign act   = (st_q == ST_RUN);

  pbus_tick_gen u_tick (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (start),
    .run   (run),
    .slow  (slow_q),
    .tick  (tick)
  );

  pbus_win #(.N(NSTB)) u_win (
    .t     (t_q),
    .on_t  ({cfg_q.re_on,  cfg_q.we_on,  cfg_q.cs_on}),
    .off_t ({cfg_q.re_off, cfg_q.we_off, cfg_q.cs_off}),
    .hit   (hit)
  );

  assign cur_len = rd_q ? cfg_q.rd_len : cfg_q.wr_len;

  // next state
  always_comb begin
    st_d   = st_q;
    t_d    = t_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          st_d = ST_RUN;
          t_d  = '0;
        end
      end
      ST_RUN: begin
        if (tick) begin
          if (t_q == cur_len) begin
            done_d = 1'b1;
            t_d    = '0;
            st_d   = (cfg_q.gap == '0) ? ST_IDLE : ST_GAP;
          end else begin
            t_d = t_q + 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (tick_t'(t_q + 1'b1) == cfg_q.gap) begin
            st_d = ST_IDLE;
            t_d  = '0;
          end else begin
            t_d = t_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    cap_en = act & rd_q & tick & (t_q == cfg_q.acc);
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      t_q    <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      t_q    <= t_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cfg_q  <= '0;
      slow_q <= 1'b0;
      rd_q   <= 1'b0;
      a0_q   <= 1'b0;
      wdat_q <= '0;
    end else if (start) begin
      cfg_q  <= cfg_in;
      slow_q <= slow_tick;
      rd_q   <= req_rd;
      a0_q   <= ~req_cmd;
      wdat_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdat_q <= '0;
    end else if (cap_en) begin
      rdat_q <= bus_din;
    end
  end

  // pins
  assign cs_act = act & hit[0];
  assign we_act = act & ~rd_q & hit[1];
  assign re_act = act &  rd_q & hit[2];

  assign cs_o     = ~cs_act ^ pol[0];
  assign we_o     = ~we_act ^ pol[1];
  assign re_o     = ~re_act ^ pol[2];
  assign a0_o     = a0_q ^ pol[3];
  assign bus_oe   = cs_act & ~rd_q;
  assign bus_dout = wdat_q;
  assign rd_data  = rdat_q;
  assign busy     = run;
  assign done     = done_q;
endmodule

// File: rtl/pbus_strobe_timer_chk.sv
`timescale 1ns/1ps
module pbus_strobe_timer_chk
  import pbus_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic [NPOL-1:0] pol,
  input logic            cs_o,
  input logic            we_o,
  input logic            re_o,
  input logic            a0_o,
  input logic            bus_oe,
  input logic            busy,
  input logic            done
);
  logic cs_act, we_act, re_act;
  assign cs_act = (cs_o == pol[0]);
  assign we_act = (we_o == pol[1]);
  assign re_act = (re_o == pol[2]);

  // R9
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_act && re_act));

  // R8
  oe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (cs_act && !re_act));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cs_act && !we_act && !re_act && !bus_oe));

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cs_act && !we_act && !re_act));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));

  // R10
  a0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(pol)) |-> $stable(a0_o));
endmodule

bind pbus_strobe_timer pbus_strobe_timer_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req    (req),
  .pol    (pol),
  .cs_o   (cs_o),
  .we_o   (we_o),
  .re_o   (re_o),
  .a0_o   (a0_o),
  .bus_oe (bus_oe),
  .busy   (busy),
  .done   (done)
);

// File: tb/tb_pbus_strobe_timer.sv
`timescale 1ns/1ps
module tb_pbus_strobe_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk, rst_n, req, req_cmd, req_rd, slow_tick;
  logic [DW-1:0] wr_data, bus_din, bus_dout, rd_data;
  logic [31:0]   time_a, time_b;
  logic [3:0]    pol;
  logic          cs_o, we_o, re_o, a0_o, bus_oe, busy, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [DW-1:0] exp_rd = '0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_strobe_timer #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_cmd(req_cmd), .req_rd(req_rd),
    .wr_data(wr_data), .time_a(time_a), .time_b(time_b), .slow_tick(slow_tick),
    .pol(pol), .bus_din(bus_din), .cs_o(cs_o), .we_o(we_o), .re_o(re_o),
    .a0_o(a0_o), .bus_oe(bus_oe), .bus_dout(bus_dout), .rd_data(rd_data),
    .busy(busy), .done(done)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_reset();
    rst_n = 1'b0; req = 1'b0; req_cmd = 1'b0; req_rd = 1'b0; slow_tick = 1'b0;
    wr_data = '0; bus_din = '0; time_a = '0; time_b = '0; pol = 4'b0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13: idle levels with active-low strobes
    chk({busy, done, bus_oe} == 3'b000, "R13", "busy/done/oe", {busy, done, bus_oe}, 0);
    chk({cs_o, we_o, re_o} == 3'b111, "R13", "strobes idle", {cs_o, we_o, re_o}, 7);
    chk(rd_data == '0, "R13", "rd_data", rd_data, 0);
  endtask

  task automatic run_access(input bit rd, input bit cmd,
                            input int cson, input int csoff, input int weon, input int weoff,
                            input int reon, input int reoff, input int wl, input int rl,
                            input int gap, input int acc, input bit slow,
                            input logic [DW-1:0] wd, input logic [DW-1:0] dbase,
                            input bit disturb, input string tag);
    int we_off_c, re_off_c, cs_off_c, acc_c, wl_c, rl_c, d, len, last;
    logic [6:0] exp_v, act_v;
    we_off_c = imax(weoff, weon + 1);
    re_off_c = imax(reoff, reon + 1);
    cs_off_c = imax(imax(csoff, cson + 1), imax(we_off_c, re_off_c));
    acc_c    = imax(acc, reon + 1);
    wl_c     = imax(wl, we_off_c);
    rl_c     = imax(imax(rl, re_off_c), acc_c);
    d        = slow ? 2 : 1;
    len      = rd ? rl_c : wl_c;
    last     = (len + 1 + gap) * d + 2;
    @(negedge clk);
    time_a = {2'b00, reoff[5:0], reon[3:0], weoff[5:0], weon[3:0], csoff[5:0], cson[3:0]};
    time_b = {4'h0, acc[5:0], 4'h0, gap[5:0], rl[5:0], wl[5:0]};
    slow_tick = slow; req = 1'b1; req_cmd = cmd; req_rd = rd; wr_data = wd;
    for (int n = 1; n <= last; n++) begin
      int t;
      bit in_run, ecs, ewe, ere, eoe, ebusy, edone;
      @(negedge clk);
      if (n == 1) begin
        req = 1'b0;
        if (disturb) begin
          time_a = 32'h0; time_b = 32'hFFFF_FFFF; slow_tick = ~slow; wr_data = ~wd;
        end
      end
      if (disturb && n == 3) req = 1'b1;
      if (disturb && n == 4) req = 1'b0;
      in_run = (n <= (len + 1) * d);
      t      = (n - 1) / d;
      ecs    = in_run && t >= cson && t < cs_off_c;
      ewe    = in_run && !rd && t >= weon && t < we_off_c;
      ere    = in_run && rd && t >= reon && t < re_off_c;
      eoe    = ecs && !rd;
      ebusy  = (n <= (len + 1 + gap) * d);
      edone  = (n == (len + 1) * d + 1);
      exp_v  = {ecs ? pol[0] : ~pol[0], ewe ? pol[1] : ~pol[1], ere ? pol[2] : ~pol[2],
                (~cmd) ^ pol[3], eoe, ebusy, edone};
      act_v  = {cs_o, we_o, re_o, a0_o, bus_oe, busy, done};
      chk(act_v == exp_v, tag, $sformatf("pins{cs,we,re,a0,oe,busy,done} n=%0d", n),
          act_v, exp_v);
      if (eoe) chk(bus_dout == wd, tag, $sformatf("bus_dout n=%0d", n), bus_dout, wd);
      bus_din = dbase + DW'(n);
    end
    if (rd) exp_rd = dbase + DW'((acc_c + 1) * d);
    // R9: capture point on reads, held value across writes
    chk(rd_data == exp_rd, tag, "R9 rd_data", rd_data, exp_rd);
  endtask

  initial begin
    check_reset();
    // R1 R2 R3 R9: plain read, distinct field values
    run_access(1, 0, 1, 9, 2, 6, 3, 7, 10, 12, 2, 5, 0, 16'h1234, 16'h0100, 0,
               "R1 R2 R3 R9 R11");
    // R8 R10: write of a command; rd_data must stay held
    run_access(0, 1, 1, 9, 2, 6, 3, 7, 10, 12, 2, 5, 0, 16'hA5C3, 16'h0200, 0,
               "R3 R8 R9 R10 R11");
    // R4 R7: doubled tick, every polarity inverted, assert tick zero
    pol = 4'b1111;
    run_access(1, 0, 0, 8, 1, 4, 2, 6, 8, 9, 1, 4, 1, 16'h0000, 16'h0300, 0,
               "R4 R7 R9");
    run_access(0, 0, 0, 8, 1, 4, 2, 6, 8, 9, 3, 4, 1, 16'h5A5A, 16'h0000, 0,
               "R4 R7 R8");
    pol = 4'b0000;
    // R5 R6: collapsed and inverted fields
    run_access(0, 1, 5, 2, 3, 3, 4, 1, 0, 0, 0, 0, 0, 16'h0F0F, 16'h0000, 0,
               "R5 R6 R8");
    run_access(1, 1, 5, 2, 3, 3, 4, 1, 0, 0, 0, 0, 0, 16'h0000, 16'h0400, 0,
               "R5 R6 R9");
    // R12 R11: configuration scrambled and request raised mid-access
    run_access(0, 0, 1, 9, 2, 6, 3, 7, 10, 12, 2, 5, 0, 16'h3C3C, 16'h0000, 1,
               "R12 R11 R8");
    run_access(1, 0, 1, 9, 2, 6, 3, 7, 10, 12, 2, 5, 1, 16'h0000, 16'h0500, 1,
               "R12 R4 R9");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule